// File: doc/BRIEF.md
# Dual-Mode Serial Clock Rate Generator

This block turns a fast module clock into the serial clock of a synchronous serial shift engine. Two division schemes share one control word. One is a linear even divider that slows the module clock by 2·(n+1) for an 8-bit value n. The other is a power-of-two divider that slows it by 2^(m+1) for a 4-bit value m. A mode bit in the same word picks between them. Either way the serial clock has a 50% duty cycle, because it toggles once per half period.

The shift engine raises `run` for the length of a transfer. The control word is captured in the first cycle that `run` is seen high. The counter starts from zero at that point, so the first serial clock edge comes exactly one half period later. The clock then runs at that rate until `run` drops, whatever the control word does in the meantime. Alongside the clock level, the block gives one-cycle rising and falling strobes so the shifter can launch and capture data on the right edges. When no transfer is running, the clock rests at the idle polarity input. The arithmetic that picks a divider value for a target rate is left to software.

Top module: `sclk_rate_gen`

## Requirements
- R1: With `div_ctrl[12]` = 1 (linear mode), the serial clock toggles every n+1 module clock cycles, where n = `div_ctrl[7:0]`.
- R2: With `div_ctrl[12]` = 0 (power-of-two mode), the serial clock toggles every 2^m module clock cycles, where m = `div_ctrl[11:8]`. The value m = 15 gives 32768 cycles.
- R3: In linear mode with n = 0, the serial clock toggles on every module clock cycle, which is half the module clock rate.
- R4: During a transfer, every interval between consecutive serial clock edges is the same length, and the edges alternate between rising and falling. This gives a 50% duty cycle.
- R5: Whenever `run` was low at the previous clock edge, `sclk` equals the `cpol` value sampled at that edge, and both strobes are low.
- R6: The control word is captured in the first cycle that `run` is high. Changing `div_ctrl` while `run` stays high does not change the edge spacing.
- R7: The first serial clock edge is registered exactly H module clock edges after the start edge, where H is the half period.
- R8: `sclk_rise` is high for exactly the cycle in which `sclk` has just gone 0 to 1. `sclk_fall` is high for exactly the cycle in which `sclk` has just gone 1 to 0. The two strobes are never high together, and no strobe appears without a level change.
- R9: While the synchronous reset `rst` is high, `sclk` follows `cpol` and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | High for the length of a transfer |
| div_ctrl | input | 13 | Divider control word: [7:0] linear value, [11:8] exponent, [12] mode (1 = linear) |
| cpol | input | 1 | Idle level of the serial clock |
| sclk | output | 1 | Serial clock level (registered) |
| sclk_rise | output | 1 | One-cycle strobe on a 0 to 1 serial clock transition |
| sclk_fall | output | 1 | One-cycle strobe on a 1 to 0 serial clock transition |

## Verification
Directed cases cover the extremes of each field:
- a linear value of 0 and of 255;
- exponents of 0 and 15.

An exponent of 0 and a linear value of 0 both produce a half period of one cycle. Comparing them shows whether the mode bit selects the correct field. The exponent of 15 shows whether the counter is wide enough.

A seeded random mix of modes, field values, polarities and edge counts then measures the cycle of every edge against a half period computed in the bench. This separates an off-by-one in the first edge from an error in the steady spacing. One case rewrites the control word in the middle of a transfer, which shows whether the word is held from the start. Each transfer ends with a check of the idle level and the strobes.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;

  // Divider scheme selected by the mode bit of the control word
  typedef enum logic {
    DIV_POW2   = 1'b0,
    DIV_LINEAR = 1'b1
  } div_mode_e;

endpackage

// File: rtl/sclk_ratio_decode.sv
// Turns the control word into (half period - 1) in module clock cycles.
module sclk_ratio_decode
  import sclk_div_pkg::*;
#(
  parameter int LIN_W  = 8,
  parameter int EXP_W  = 4,
  parameter int CNT_W  = 16,
  parameter int CTRL_W = LIN_W + EXP_W + 1
) (
  input  logic [CTRL_W-1:0] ctrl,
  output logic [CNT_W-1:0]  half_m1
);

  localparam int EXP_LO   = LIN_W;
  localparam int MODE_BIT = LIN_W + EXP_W;

  logic [LIN_W-1:0] lin_f;
  logic [EXP_W-1:0] exp_f;
  div_mode_e        mode;
  logic [CNT_W-1:0] pow_mask;

  assign lin_f = ctrl[LIN_W-1:0];
  assign exp_f = ctrl[EXP_LO +: EXP_W];
  assign mode  = div_mode_e'(ctrl[MODE_BIT]);

  // 2^m - 1 is a mask with the lowest m bits set
  for (genvar g = 0; g < CNT_W; g++) begin : g_mask
    assign pow_mask[g] = (g < int'(exp_f));
  end

  always_comb begin
    if (mode == DIV_LINEAR) half_m1 = {{(CNT_W-LIN_W){1'b0}}, lin_f};
    else                    half_m1 = pow_mask;
  end

endmodule

// File: rtl/sclk_halfper_counter.sv
// Counts module clocks within a half period; tick marks the last one.
module sclk_halfper_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [CNT_W-1:0] limit,
  output logic             tick
);

  logic [CNT_W-1:0] cnt;

  assign tick = go && (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || !go)  cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/sclk_edge_gen.sv
// Holds the serial clock level and produces registered edge strobes.
module sclk_edge_gen (
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  logic tick,
  input  logic idle_lvl,
  output logic sclk_q,
  output logic rise_q,
  output logic fall_q
);

  always_ff @(posedge clk) begin
    if (rst || !go) begin
      sclk_q <= idle_lvl;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else if (tick) begin
      sclk_q <= ~sclk_q;
      rise_q <= ~sclk_q;
      fall_q <= sclk_q;
    end else begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end
  end

endmodule

// File: rtl/sclk_rate_gen.sv
// Dual-mode serial clock rate generator: linear even or power-of-two division.
module sclk_rate_gen #(
  parameter int LIN_W = 8,
  parameter int EXP_W = 4,
  localparam int CTRL_W = LIN_W + EXP_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [CTRL_W-1:0] div_ctrl,
  input  logic              cpol,
  output logic              sclk,
  output logic              sclk_rise,
  output logic              sclk_fall
);

  // Wide enough for both 2^LIN_W and 2^(2^EXP_W - 1)
  localparam int POW_MAX_W = 1 << EXP_W;
  localparam int CNT_W     = (LIN_W + 1 > POW_MAX_W) ? LIN_W + 1 : POW_MAX_W;

  logic             running;
  logic             start;
  logic             go;
  logic             tick;
  logic [CNT_W-1:0] half_dec;
  logic [CNT_W-1:0] half_lat;

  assign start = run && !running;
  assign go    = run && running;

  always_ff @(posedge clk) begin
    if (rst) running <= 1'b0;
    else     running <= run;
  end

  sclk_ratio_decode #(
    .LIN_W (LIN_W),
    .EXP_W (EXP_W),
    .CNT_W (CNT_W)
  ) u_decode (
    .ctrl    (div_ctrl),
    .half_m1 (half_dec)
  );

  // Rate frozen at the start of a transfer
  always_ff @(posedge clk) begin
    if (rst)        half_lat <= '0;
    else if (start) half_lat <= half_dec;
  end

  sclk_halfper_counter #(
    .CNT_W (CNT_W)
  ) u_count (
    .clk   (clk),
    .rst   (rst),
    .go    (go),
    .limit (half_lat),
    .tick  (tick)
  );

  sclk_edge_gen u_edges (
    .clk      (clk),
    .rst      (rst),
    .go       (go),
    .tick     (tick),
    .idle_lvl (cpol),
    .sclk_q   (sclk),
    .rise_q   (sclk_rise),
    .fall_q   (sclk_fall)
  );

endmodule

// File: rtl/sclk_rate_gen_chk.sv
// Property checker for sclk_rate_gen, bound below.
module sclk_rate_gen_chk (
  input logic clk,
  input logic rst,
  input logic run,
  input logic cpol,
  input logic sclk,
  input logic sclk_rise,
  input logic sclk_fall
);

  logic [31:0] gap_cnt;
  logic [31:0] last_gap;
  logic        have_edge;
  logic        have_gap;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      gap_cnt   <= '0;
      last_gap  <= '0;
      have_edge <= 1'b0;
      have_gap  <= 1'b0;
    end else if (sclk_rise || sclk_fall) begin
      gap_cnt   <= 32'd1;
      have_edge <= 1'b1;
      if (have_edge) begin
        last_gap <= gap_cnt;
        have_gap <= 1'b1;
      end
    end else begin
      gap_cnt <= gap_cnt + 32'd1;
    end
  end

  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(sclk_rise && sclk_fall));

  assert_rise_level_R8: assert property (@(posedge clk) disable iff (rst)
    sclk_rise |-> (sclk && !$past(sclk)));

  assert_fall_level_R8: assert property (@(posedge clk) disable iff (rst)
    sclk_fall |-> (!sclk && $past(sclk)));

  assert_idle_level_R5: assert property (@(posedge clk) disable iff (rst)
    !run |=> (sclk == $past(cpol)) && !sclk_rise && !sclk_fall);

  assert_change_strobed_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(run, 2) && $past(run) && (sclk != $past(sclk))) |-> (sclk_rise || sclk_fall));

  assert_even_gap_R4: assert property (@(posedge clk) disable iff (rst)
    ((sclk_rise || sclk_fall) && have_gap) |-> (gap_cnt == last_gap));

endmodule

bind sclk_rate_gen sclk_rate_gen_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .run       (run),
  .cpol      (cpol),
  .sclk      (sclk),
  .sclk_rise (sclk_rise),
  .sclk_fall (sclk_fall)
);

// File: tb/sclk_rate_gen_tb_top.sv
module sclk_rate_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0;
  logic [12:0] div_ctrl = '0;
  logic        cpol = 1'b0;
  logic        sclk;
  logic        sclk_rise;
  logic        sclk_fall;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk; // 50 MHz

  sclk_rate_gen dut_i (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .div_ctrl  (div_ctrl),
    .cpol      (cpol),
    .sclk      (sclk),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall)
  );

  // Half period in module clocks, from R1/R2
  function automatic int half_of(input logic [12:0] c);
    if (c[12]) return int'(c[7:0]) + 1;
    else       return 1 << c[11:8];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One transfer: count negedge samples from the start and check every edge
  task automatic run_case(input logic [12:0] c, input logic pol, input int nedges,
                          input bit change_mid);
    int h;
    int t;
    int edges;
    logic lvl;
    string rq;
    h = half_of(c);
    rq = (c[12]) ? ((c[7:0] == 0) ? "R3" : "R1") : "R2";
    @(negedge clk);
    cpol = pol;
    div_ctrl = c;
    run = 1'b1;
    t = 0;
    edges = 0;
    lvl = pol;
    while (edges < nedges && t <= 1 + (nedges + 1) * h) begin
      @(negedge clk);
      t++;
      if (change_mid && t == 2) div_ctrl = c ^ 13'h1_0A5;
      if (sclk != lvl) begin
        edges++;
        if (edges == 1) check(t == 1 + h, "R7 first edge time", t, 1 + h);
        else if (change_mid) check(t == 1 + edges * h, "R6 spacing after ctrl change", t, 1 + edges * h);
        else check(t == 1 + edges * h, {rq, "/R4 edge time"}, t, 1 + edges * h);
        check(sclk_rise == sclk && sclk_fall == !sclk, "R8 strobe on edge",
              {sclk_rise, sclk_fall}, {sclk, !sclk});
        lvl = sclk;
      end else if (sclk_rise || sclk_fall) begin
        check(1'b0, "R8 strobe without edge", {sclk_rise, sclk_fall}, 0);
      end
    end
    check(edges == nedges, "R4 edge count", edges, nedges);
    run = 1'b0;
    @(negedge clk);
    check(sclk == pol && !sclk_rise && !sclk_fall, "R5 idle after stop",
          {sclk, sclk_rise, sclk_fall}, {pol, 2'b00});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R9: reset follows cpol
    cpol = 1'b1;
    repeat (3) @(negedge clk);
    check(sclk == 1'b1 && !sclk_rise && !sclk_fall, "R9 reset cpol=1",
          {sclk, sclk_rise, sclk_fall}, 3'b100);
    cpol = 1'b0;
    @(negedge clk);
    check(sclk == 1'b0 && !sclk_rise && !sclk_fall, "R9 reset cpol=0",
          {sclk, sclk_rise, sclk_fall}, 3'b000);
    rst = 1'b0;
    // R5: idle with run low
    cpol = 1'b1;
    repeat (4) @(negedge clk);
    check(sclk == 1'b1 && !sclk_rise && !sclk_fall, "R5 idle level",
          {sclk, sclk_rise, sclk_fall}, 3'b100);

    // Directed corners
    run_case({1'b1, 4'h0, 8'd0},   1'b0, 8, 1'b0); // R3 fastest
    run_case({1'b1, 4'hF, 8'd255}, 1'b1, 4, 1'b0); // R1 largest linear
    run_case({1'b0, 4'h0, 8'hFF},  1'b0, 6, 1'b0); // R2 m=0
    run_case({1'b0, 4'd3, 8'd7},   1'b1, 6, 1'b0); // R2 m=3
    run_case({1'b1, 4'd2, 8'd5},   1'b0, 6, 1'b1); // R6 change mid-run
    run_case({1'b0, 4'hF, 8'd0},   1'b0, 1, 1'b0); // R2 m=15

    // Random mix
    for (int i = 0; i < 12; i++) begin
      logic [12:0] c;
      c[12]   = 1'($urandom_range(0, 1));
      c[11:8] = 4'($urandom_range(0, 7));
      c[7:0]  = 8'($urandom_range(0, 255));
      run_case(c, 1'($urandom_range(0, 1)), $urandom_range(4, 7), 1'b0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule